// File: doc/BRIEF.md
# Immediate-Count Rotate-Right Execution Unit

This execution-stage unit rotates a register operand to the right by a count taken from an 8-bit immediate. It never reads or writes the arithmetic flags, and it has no flag ports at all. A decoder upstream hands it one request per cycle. Each request carries a 64-bit source operand, the immediate count, the operand-width select bit, the vector-length bit and the current processor mode. Exactly one cycle later the unit returns either a destination value or an invalid-opcode fault.

The unit works out the effective operand size from the processor mode and the width select bit. It masks the count to the width of that operand. The rotate itself is a six-stage logarithmic barrel rotator, and its largest stage is gated off for 32-bit operands. Illegal encodings and illegal modes are turned into a fault instead of a result.

Mode encoding on `in_mode`: 0 = real, 1 = virtual-8086, 2 = protected/compatibility, 3 = 64-bit.

Top module: `imm_rotr_unit`

## Requirements
- R1: When the effective size is 32 bits, `out_data[31:0]` is `in_src[31:0]` rotated right by `in_imm & 0x1F`, and `out_data[63:32]` is zero.
- R2: In mode 3 with `in_wide`=1, the effective size is 64 bits and `out_data` is all of `in_src` rotated right by `in_imm & 0x3F`.
- R3: In mode 2 the effective size is 32 bits whatever the value of `in_wide`. In mode 3 with `in_wide`=0 it is also 32 bits.
- R4: A request with `in_len`=1 gives `out_fault`=1 and `out_data`=0.
- R5: A request in mode 0 or mode 1 gives `out_fault`=1 and `out_data`=0.
- R6: When the masked count is zero, the result is the source unchanged: the full 64 bits for a 64-bit operand, and the low 32 bits zero-extended for a 32-bit operand.
- R7: `out_valid` equals `in_valid` one clock later. Whenever `out_valid`=0 or `out_fault`=1, `out_data` is zero.
- R8: While `rst_n` is low at a clock edge, `out_valid`, `out_fault` and `out_data` all become zero.
- R9: Immediate bits above the mask have no effect on the result: bits 7:6 are always ignored, and bit 5 is ignored for 32-bit operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_src | input | 64 | Source operand |
| in_imm | input | 8 | Immediate rotate count |
| in_wide | input | 1 | Operand-width select (1 asks for 64 bits) |
| in_len | input | 1 | Vector-length bit; must be 0 for a legal request |
| in_mode | input | 2 | Processor mode (0 real, 1 virtual-8086, 2 protected, 3 64-bit) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Destination value, zero on a fault |
| out_fault | output | 1 | Invalid-opcode fault |

## Verification
The bench aims at the count boundaries: 0, 1, 31, 32, 63, 64 and 0xFF, in both operand sizes. A design that masked the count wrongly would rotate 32-bit operands by 32, or would let bits 7:6 change the result. A design that shifted by the full width on a zero count would return a corrupted value instead of the source.

The bench also sends the width select bit in protected mode, where it must be ignored. A design that honoured it there would rotate all 64 bits and leave data in the upper half. Faulting requests are mixed between legal ones; a design that let such a request through would show a non-zero result or a missing fault. Back-to-back traffic and idle gaps expose any slip in the one-cycle latency.

// File: rtl/rotr_pkg.sv
// Package: shared widths and the processor-mode encoding for the rotate unit.
// Assumes the data width is a power of two, so that the count is log2(width) bits.
package rotr_pkg;
    localparam int DATA_W = 64;
    localparam int IMM_W  = 8;
    localparam int AMT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        MODE_REAL  = 2'd0,
        MODE_V86   = 2'd1,
        MODE_PROT  = 2'd2,
        MODE_LONG  = 2'd3
    } cpu_mode_e;
endpackage

// File: rtl/rotr_size_decode.sv
// Module: rotr_size_decode
// Works out the effective operand size and whether the request is illegal.
// Assumes: the width select bit is honoured only in the 64-bit mode, the
// vector-length bit must be zero, and the real and virtual-8086 modes fault.
module rotr_size_decode
    import rotr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       wide_sel,
    input  logic       len_sel,
    output logic       is_wide,
    output logic       illegal
);
    cpu_mode_e mode_e;

    // Purpose: turn the raw mode bits into the enumerated mode.
    always_comb mode_e = cpu_mode_e'(mode);

    // Purpose: 64-bit operand only in the 64-bit mode with the width bit set.
    always_comb is_wide = (mode_e == MODE_LONG) && wide_sel;

    // Purpose: fault on a set length bit or on a disallowed mode.
    always_comb illegal = len_sel || (mode_e == MODE_REAL) || (mode_e == MODE_V86);
endmodule

// File: rtl/rotr_count_mask.sv
// Module: rotr_count_mask
// Reduces the immediate to a rotate amount that fits the effective operand size.
// Assumes: the top bit of the amount is cleared for the narrow operand size.
module rotr_count_mask #(
    parameter int IMM_W = 8,
    parameter int AMT_W = 6
) (
    input  logic [IMM_W-1:0] imm,
    input  logic             is_wide,
    output logic [AMT_W-1:0] amt
);
    localparam logic [AMT_W-1:0] WIDE_MASK   = '1;
    localparam logic [AMT_W-1:0] NARROW_MASK = {1'b0, {(AMT_W-1){1'b1}}};

    // Purpose: keep only the count bits that are meaningful for this operand size.
    always_comb amt = imm[AMT_W-1:0] & (is_wide ? WIDE_MASK : NARROW_MASK);
endmodule

// File: rtl/rotr_barrel.sv
// Module: rotr_barrel
// Logarithmic barrel rotator: stage s rotates by 2**s when amount bit s is set.
// For a narrow operand the low half is rotated by itself and the upper half is
// kept at zero. Stages whose distance reaches the half width are gated off then.
// Assumes DATA_W is a power of two and AMT_W = log2(DATA_W).
module rotr_barrel #(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] src,
    input  logic [AMT_W-1:0]  amt,
    input  logic              is_wide,
    output logic [DATA_W-1:0] dst
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] stg [AMT_W+1];

    // Purpose: zero-extend the low half for a narrow operand before rotating.
    always_comb stg[0] = is_wide ? src : {{HALF{1'b0}}, src[HALF-1:0]};

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [DATA_W-1:0] rot;
        if (SH < HALF) begin : g_both
            // Purpose: rotate the full word or only the low half by SH.
            always_comb rot = is_wide ? {stg[s][SH-1:0], stg[s][DATA_W-1:SH]}
                                      : {{HALF{1'b0}}, stg[s][SH-1:0], stg[s][HALF-1:SH]};
        end else begin : g_wide_only
            // Purpose: the half-width stage takes part only for the wide operand.
            always_comb rot = is_wide ? {stg[s][SH-1:0], stg[s][DATA_W-1:SH]} : stg[s];
        end
        // Purpose: take the rotated value when this amount bit is set.
        always_comb stg[s+1] = amt[s] ? rot : stg[s];
    end

    // Purpose: the last stage is the result.
    always_comb dst = stg[AMT_W];
endmodule

// File: rtl/imm_rotr_unit.sv
// Module: imm_rotr_unit (top)
// Rotate-right by an immediate, with no flag ports, and one registered output stage.
// Assumes a request is accepted on every cycle that in_valid is high, with no
// back-pressure. The result is forced to zero on a fault and when idle.
module imm_rotr_unit
    import rotr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic              in_wide,
    input  logic              in_len,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_fault
);
    logic              is_wide;
    logic              illegal;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] rot_val;

    rotr_size_decode u_size (
        .mode     (in_mode),
        .wide_sel (in_wide),
        .len_sel  (in_len),
        .is_wide  (is_wide),
        .illegal  (illegal)
    );

    rotr_count_mask #(.IMM_W(IMM_W), .AMT_W(AMT_W)) u_mask (
        .imm     (in_imm),
        .is_wide (is_wide),
        .amt     (amt)
    );

    rotr_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rot (
        .src     (in_src),
        .amt     (amt),
        .is_wide (is_wide),
        .dst     (rot_val)
    );

    // Purpose: register valid, fault and result; clear the result on a fault or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_fault <= in_valid && illegal;
            out_data  <= (in_valid && !illegal) ? rot_val : '0;
        end
    end
endmodule

// File: rtl/imm_rotr_unit_chk.sv
// Module: imm_rotr_unit_chk
// Checker bound to the top. It relates each request at the ports to the
// registered response on the following cycle.
module imm_rotr_unit_chk
    import rotr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_src,
    input logic [IMM_W-1:0]  in_imm,
    input logic              in_wide,
    input logic              in_len,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_fault
);
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_fault && out_data == '0));
    // R7
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_data == '0);
    // R4
    len_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_len) |=> out_fault);
    // R5
    mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode < 2'd2) |=> out_fault);
    // R1
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(in_mode == 2'd3 && in_wide)) |=> out_data[DATA_W-1:DATA_W/2] == '0);
    // R6
    zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_len && in_mode == 2'd3 && in_wide && in_imm[5:0] == 6'd0)
        |=> (out_data == $past(in_src) && !out_fault));
endmodule

bind imm_rotr_unit imm_rotr_unit_chk u_chk (.*);

// File: tb/imm_rotr_unit_tb_top.sv
// Scoreboard bench: a driver task pushes the expected response and a monitor
// pops and compares it when out_valid is seen.
module imm_rotr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_src = '0;
    logic [7:0]  in_imm = '0;
    logic        in_wide = 1'b0;
    logic        in_len = 1'b0;
    logic [1:0]  in_mode = 2'd3;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_fault;

    typedef struct {
        logic [63:0] data;
        logic        fault;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    imm_rotr_unit dut_i (.*);

    // Reference model, written from the requirements: rotate one bit at a time.
    function automatic exp_t model(logic [63:0] s, logic [7:0] imm, logic w,
                                   logic l, logic [1:0] m, string req);
        exp_t e;
        logic [63:0] x;
        int a;
        e.req = req;
        if (l || m < 2) begin
            e.data = '0;
            e.fault = 1'b1;
        end else if (m == 2'd3 && w) begin
            a = int'(imm & 8'h3F);
            x = s;
            for (int i = 0; i < a; i++) x = {x[0], x[63:1]};
            e.data = x;
            e.fault = 1'b0;
        end else begin
            a = int'(imm & 8'h1F);
            x = {32'h0, s[31:0]};
            for (int i = 0; i < a; i++) x[31:0] = {x[0], x[31:1]};
            e.data = x;
            e.fault = 1'b0;
        end
        return e;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic [63:0] s, logic [7:0] imm, logic w, logic l,
                         logic [1:0] m, string req);
        exp_q.push_back(model(s, imm, w, l, m, req));
        in_valid = 1'b1;
        in_src = s;
        in_imm = imm;
        in_wide = w;
        in_len = l;
        in_mode = m;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pop and compare each response as it appears.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.req, " fault"}, {63'd0, out_fault}, {63'd0, e.fault});
                    check({e.req, " data"}, out_data, e.data);
                end
            end
        end
    end

    // Main stimulus.
    initial begin
        logic [63:0] p;
        p = 64'h8000_0000_F00D_0001;
        fork
            begin
                repeat (3) @(negedge clk);
                // R8: outputs are cleared while reset is held low
                check("R8 out_valid", {63'd0, out_valid}, 64'd0);
                check("R8 out_fault", {63'd0, out_fault}, 64'd0);
                check("R8 out_data", out_data, 64'd0);
                rst_n = 1'b1;
                @(negedge clk);

                // R1: narrow rotate in the 64-bit mode with in_wide = 0
                drive(p, 8'd4, 1'b0, 1'b0, 2'd3, "R1");
                drive(p, 8'd31, 1'b0, 1'b0, 2'd3, "R1");
                drive(p, 8'd1, 1'b0, 1'b0, 2'd2, "R1");
                // R2: wide rotate
                drive(p, 8'd1, 1'b1, 1'b0, 2'd3, "R2");
                drive(p, 8'd31, 1'b1, 1'b0, 2'd3, "R2");
                drive(p, 8'd32, 1'b1, 1'b0, 2'd3, "R2");
                drive(p, 8'd63, 1'b1, 1'b0, 2'd3, "R2");
                // R3: the width bit is ignored in protected mode
                drive(p, 8'd8, 1'b1, 1'b0, 2'd2, "R3");
                drive(p, 8'd40, 1'b1, 1'b0, 2'd2, "R3");
                // R6: masked count of zero
                drive(p, 8'd0, 1'b1, 1'b0, 2'd3, "R6");
                drive(p, 8'd64, 1'b1, 1'b0, 2'd3, "R6");
                drive(p, 8'd32, 1'b0, 1'b0, 2'd3, "R6");
                drive(p, 8'd0, 1'b0, 1'b0, 2'd2, "R6");
                // R9: upper immediate bits are ignored
                drive(p, 8'hC5, 1'b1, 1'b0, 2'd3, "R9");
                drive(p, 8'hE3, 1'b0, 1'b0, 2'd3, "R9");
                drive(p, 8'hFF, 1'b0, 1'b0, 2'd2, "R9");
                // R4: the length bit faults
                drive(p, 8'd5, 1'b1, 1'b1, 2'd3, "R4");
                drive(p, 8'd5, 1'b0, 1'b1, 2'd2, "R4");
                // R5: real and virtual-8086 modes fault
                drive(p, 8'd5, 1'b0, 1'b0, 2'd0, "R5");
                drive(p, 8'd5, 1'b1, 1'b0, 2'd1, "R5");
                drive(p, 8'd7, 1'b0, 1'b0, 2'd3, "R1");
                idle(1);
                // R7: outputs are idle after a gap in the requests
                check("R7 idle valid", {63'd0, out_valid}, 64'd0);
                check("R7 idle data", out_data, 64'd0);
                idle(1);

                // R2 R1 R4 R5: pseudo-random traffic with bubbles
                for (int k = 0; k < 60; k++) begin
                    logic [63:0] s;
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    s[31:0] = lfsr;
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    s[63:32] = lfsr;
                    if (lfsr[9:8] == 2'd0) idle(1);
                    drive(s, lfsr[7:0], lfsr[11], (lfsr[14:12] == 3'd0), lfsr[16:15], "R2 random");
                end
                idle(3);
                check("R7 queue drained", 64'(exp_q.size()), 64'd0);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule